// File: doc/BRIEF.md
# Sixteen-Bit ALU with Condition Flags

This block is the arithmetic and logic unit of a small 16-bit microcontroller core. It is purely combinational. On each evaluation it takes a source operand, a destination operand, a 4-bit operation code, a byte-mode select and the four incoming condition flags (carry, zero, negative, overflow). From these it produces a result, a write-enable that tells the core whether to store that result, and the updated flags.

The operations fall into five groups:
- binary arithmetic: add, add with carry, subtract, subtract with carry and compare;
- bitwise logic: AND, bit-test, bit-clear, bit-set and XOR;
- packed-BCD decimal add;
- one-bit right rotates: arithmetic, and through carry;
- byte operations: byte swap and sign extension.

Subtraction adds the inverted source plus one, or plus the carry. A carry out of 1 therefore means that no borrow occurred. Compare and bit-test update the flags but do not request writeback.

The core decodes instructions, reads the register file and holds the status register. It presents the operands and the current flags here, then latches whatever the block returns.

Top module: `alu16_core`

## Requirements
- R1: The operation codes are MOV=0, ADD=1, ADDC=2, SUB=3, SUBC=4, CMP=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, DADD=11, RRA=12, RRC=13, SWPB=14 and SXT=15. MOV returns the source and passes all four incoming flags through unchanged.
- R2: ADD returns src+dst and ADDC returns src+dst+C. For both, C is the carry out of the top bit, V is set when both operands have the same sign and the result has the other sign, N equals the result's top bit, and Z is set when the result is zero.
- R3: SUB returns dst+(NOT src)+1 and SUBC returns dst+(NOT src)+C. C is the carry out of that sum, so C=1 means no borrow. V, N and Z follow the R2 rules, with NOT src taken as the second operand.
- R4: CMP computes the SUB value and flags, and BIT computes the AND value and flags. Both drive the write-enable low.
- R5: For AND, BIT and XOR, V is cleared, C equals NOT Z, and N and Z follow the result.
- R6: BIC returns (NOT src) AND dst and BIS returns src OR dst. Both leave all four flags unchanged.
- R7: DADD adds src, dst and C as packed BCD digits. A digit whose sum exceeds 9 is corrected by adding 6 and carries 1 into the next digit. C is the carry out of the top digit, V is cleared, and N and Z follow the result.
- R8: RRA and RRC shift dst right by one bit. RRA keeps the top bit and RRC moves the incoming C into the top bit. In both, C takes dst bit 0, V is cleared, and N and Z follow the result.
- R9: SWPB exchanges the two bytes of dst and leaves all flags unchanged. SXT copies dst bit 7 into bits 15..8 and sets N and Z from the result, C to NOT Z and V to 0. Both always work on the full word and ignore the byte-mode select.
- R10: With byte mode high, every other operation uses only operand bits 7..0. The result bits 15..8 are 0, N is result bit 7, C is the carry out of bit 7 (for DADD, out of the second digit), and V is the sign overflow at bit 7.
- R11: The write-enable is high for every operation except CMP and BIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcOp | input | 16 | Source operand |
| dstOp | input | 16 | Destination operand |
| opCode | input | 4 | Operation select (encoding in R1) |
| byteMode | input | 1 | Work on the low byte only |
| cIn | input | 1 | Incoming carry flag |
| zIn | input | 1 | Incoming zero flag |
| nIn | input | 1 | Incoming negative flag |
| vIn | input | 1 | Incoming overflow flag |
| result | output | 16 | Operation result |
| writeEn | output | 1 | Result should be stored |
| cOut | output | 1 | Updated carry flag |
| zOut | output | 1 | Updated zero flag |
| nOut | output | 1 | Updated negative flag |
| vOut | output | 1 | Updated overflow flag |

## Verification
The case most easily got wrong is byte mode together with a carry or overflow. The flags must then come from bit 7 rather than bit 15, and the upper result byte must clear, in the same evaluation. Directed vectors provoke this with 7Fh+01h, FFh+01h and a BCD byte sum of 99+01. Random operands then put byte mode on every opcode, including SWPB and SXT, which must ignore it. A behavioural model built on integers computes the expected result, write-enable and all four flags for each vector, and these are compared field by field.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,  OP_ADD  = 4'd1,  OP_ADDC = 4'd2,  OP_SUB  = 4'd3,
    OP_SUBC = 4'd4,  OP_CMP  = 4'd5,  OP_AND  = 4'd6,  OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,  OP_BIS  = 4'd9,  OP_XOR  = 4'd10, OP_DADD = 4'd11,
    OP_RRA  = 4'd12, OP_RRC  = 4'd13, OP_SWPB = 4'd14, OP_SXT  = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_SRC, RS_ADD, RS_AND, RS_BIC, RS_BIS, RS_XOR,
    RS_DEC, RS_RRA, RS_RRC, RS_SWAP, RS_SXT
  } resSel_e;

  typedef enum logic [2:0] {
    FL_KEEP, FL_ARITH, FL_LOGIC, FL_DEC, FL_SHIFT
  } flagMode_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_FLAG
  } carrySel_e;

  typedef struct packed {
    resSel_e   resSel;
    flagMode_e flagMode;
    carrySel_e carrySel;
    logic      invSrc;
    logic      writeEn;
    logic      wordOnly;
  } aluCtl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtl_t    ctl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctl.resSel   = RS_SRC;
    ctl.flagMode = FL_KEEP;
    ctl.carrySel = CI_ZERO;
    ctl.invSrc   = 1'b0;
    ctl.writeEn  = 1'b1;
    ctl.wordOnly = 1'b0;
    unique case (op)
      OP_MOV:  ctl.resSel = RS_SRC;
      OP_ADD:  begin ctl.resSel = RS_ADD; ctl.flagMode = FL_ARITH; end
      OP_ADDC: begin ctl.resSel = RS_ADD; ctl.flagMode = FL_ARITH; ctl.carrySel = CI_FLAG; end
      OP_SUB:  begin ctl.resSel = RS_ADD; ctl.flagMode = FL_ARITH; ctl.carrySel = CI_ONE;
                     ctl.invSrc = 1'b1; end
      OP_SUBC: begin ctl.resSel = RS_ADD; ctl.flagMode = FL_ARITH; ctl.carrySel = CI_FLAG;
                     ctl.invSrc = 1'b1; end
      OP_CMP:  begin ctl.resSel = RS_ADD; ctl.flagMode = FL_ARITH; ctl.carrySel = CI_ONE;
                     ctl.invSrc = 1'b1; ctl.writeEn = 1'b0; end
      OP_AND:  begin ctl.resSel = RS_AND; ctl.flagMode = FL_LOGIC; end
      OP_BIT:  begin ctl.resSel = RS_AND; ctl.flagMode = FL_LOGIC; ctl.writeEn = 1'b0; end
      OP_BIC:  ctl.resSel = RS_BIC;
      OP_BIS:  ctl.resSel = RS_BIS;
      OP_XOR:  begin ctl.resSel = RS_XOR; ctl.flagMode = FL_LOGIC; end
      OP_DADD: begin ctl.resSel = RS_DEC; ctl.flagMode = FL_DEC; ctl.carrySel = CI_FLAG; end
      OP_RRA:  begin ctl.resSel = RS_RRA; ctl.flagMode = FL_SHIFT; end
      OP_RRC:  begin ctl.resSel = RS_RRC; ctl.flagMode = FL_SHIFT; end
      OP_SWPB: begin ctl.resSel = RS_SWAP; ctl.wordOnly = 1'b1; end
      OP_SXT:  begin ctl.resSel = RS_SXT; ctl.flagMode = FL_LOGIC; ctl.wordOnly = 1'b1; end
      default: ctl.resSel = RS_SRC;
    endcase
  end

  // Compare and bit-test never ask for writeback; all other codes do.
  always_comb begin
    if (op == OP_CMP || op == OP_BIT) begin
      assert_nowrite_test_R4: assert (!ctl.writeEn);
      assert_test_flags_R4: assert (ctl.flagMode != FL_KEEP);
    end else begin
      assert_write_others_R11: assert (ctl.writeEn);
    end
  end

endmodule

// File: rtl/alu16_dpath.sv
module alu16_dpath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  aluCtl_t          ctl,
  input  logic             byteMode,
  input  logic [WIDTH-1:0] srcOp,
  input  logic [WIDTH-1:0] dstOp,
  input  logic             cIn,
  input  logic             zIn,
  input  logic             nIn,
  input  logic             vIn,
  output logic [WIDTH-1:0] result,
  output logic             cOut,
  output logic             zOut,
  output logic             nOut,
  output logic             vOut
);

  localparam int HALF      = WIDTH / 2;
  localparam int DIGITS    = WIDTH / 4;
  localparam int HALF_DIGS = HALF / 4;

  logic             effByte;
  logic [WIDTH-1:0] mask, opA, opB, opS;
  logic             carryIn;
  logic [WIDTH:0]   sumFull;
  logic             addCarry, decCarry;
  logic [DIGITS:0]  decC;
  logic [WIDTH-1:0] decSum;
  logic [WIDTH-1:0] shifted;
  logic             topA, topB, topR;
  logic [WIDTH-1:0] rawRes;
  logic             resZero;

  assign effByte = byteMode & ~ctl.wordOnly;
  assign mask    = effByte ? {{HALF{1'b0}}, {HALF{1'b1}}} : {WIDTH{1'b1}};
  assign opA     = dstOp & mask;
  assign opS     = srcOp & mask;
  assign opB     = (ctl.invSrc ? ~srcOp : srcOp) & mask;

  always_comb begin
    unique case (ctl.carrySel)
      CI_ONE:  carryIn = 1'b1;
      CI_FLAG: carryIn = cIn;
      default: carryIn = 1'b0;
    endcase
  end

  // Binary adder; byte-mode carry is taken at the byte boundary.
  assign sumFull  = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign addCarry = effByte ? sumFull[HALF] : sumFull[WIDTH];

  // BCD ripple across nibble digits.
  always_comb begin
    logic [4:0] rawDig;
    decC[0] = carryIn;
    decSum  = '0;
    for (int d = 0; d < DIGITS; d++) begin
      rawDig = {1'b0, opA[4*d +: 4]} + {1'b0, opB[4*d +: 4]} + {4'd0, decC[d]};
      if (rawDig > 5'd9) begin
        rawDig    = rawDig + 5'd6;
        decC[d+1] = 1'b1;
      end else begin
        decC[d+1] = 1'b0;
      end
      decSum[4*d +: 4] = rawDig[3:0];
    end
  end
  assign decCarry = effByte ? decC[HALF_DIGS] : decC[DIGITS];

  assign topA = effByte ? opA[HALF-1] : opA[WIDTH-1];
  assign topB = effByte ? opB[HALF-1] : opB[WIDTH-1];

  always_comb begin
    logic shiftIn;
    shiftIn = (ctl.resSel == RS_RRA) ? topA : cIn;
    shifted = opA >> 1;
    if (effByte) shifted[HALF-1]  = shiftIn;
    else         shifted[WIDTH-1] = shiftIn;
  end

  always_comb begin
    unique case (ctl.resSel)
      RS_SRC:  rawRes = opS;
      RS_ADD:  rawRes = sumFull[WIDTH-1:0];
      RS_AND:  rawRes = opS & opA;
      RS_BIC:  rawRes = ~opS & opA;
      RS_BIS:  rawRes = opS | opA;
      RS_XOR:  rawRes = opS ^ opA;
      RS_DEC:  rawRes = decSum;
      RS_RRA:  rawRes = shifted;
      RS_RRC:  rawRes = shifted;
      RS_SWAP: rawRes = {dstOp[HALF-1:0], dstOp[WIDTH-1:HALF]};
      RS_SXT:  rawRes = {{HALF{dstOp[HALF-1]}}, dstOp[HALF-1:0]};
      default: rawRes = opS;
    endcase
  end

  assign result  = rawRes & mask;
  assign topR    = effByte ? result[HALF-1] : result[WIDTH-1];
  assign resZero = (result == '0);

  always_comb begin
    cOut = cIn; zOut = zIn; nOut = nIn; vOut = vIn;
    if (ctl.flagMode != FL_KEEP) begin
      zOut = resZero;
      nOut = topR;
      vOut = 1'b0;
      unique case (ctl.flagMode)
        FL_ARITH: begin cOut = addCarry; vOut = (topA == topB) && (topR != topA); end
        FL_LOGIC: cOut = ~resZero;
        FL_DEC:   cOut = decCarry;
        FL_SHIFT: cOut = opA[0];
        default:  cOut = cIn;
      endcase
    end
  end

  // Byte mode clears the upper result byte for everything but swap/extend.
  always_comb begin
    if (effByte) assert_upper_clear_R10: assert (result[WIDTH-1:HALF] == '0);
    if (ctl.flagMode == FL_SHIFT) assert_shift_carry_R8: assert (cOut == dstOp[0]);
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
(
  input  logic [15:0] srcOp,
  input  logic [15:0] dstOp,
  input  logic [3:0]  opCode,
  input  logic        byteMode,
  input  logic        cIn,
  input  logic        zIn,
  input  logic        nIn,
  input  logic        vIn,
  output logic [15:0] result,
  output logic        writeEn,
  output logic        cOut,
  output logic        zOut,
  output logic        nOut,
  output logic        vOut
);

  aluCtl_t ctl;

  alu16_ctrl ctrl_i (
    .opCode (opCode),
    .ctl    (ctl)
  );

  alu16_dpath #(.WIDTH(16)) dpath_i (
    .ctl      (ctl),
    .byteMode (byteMode),
    .srcOp    (srcOp),
    .dstOp    (dstOp),
    .cIn      (cIn),
    .zIn      (zIn),
    .nIn      (nIn),
    .vIn      (vIn),
    .result   (result),
    .cOut     (cOut),
    .zOut     (zOut),
    .nOut     (nOut),
    .vOut     (vOut)
  );

  assign writeEn = ctl.writeEn;

  // Cross-module checks on the ports.
  always_comb begin
    if (opCode == 4'd0 || opCode == 4'd8 || opCode == 4'd9 || opCode == 4'd14) begin
      assert_flags_hold_R6: assert (cOut == cIn && zOut == zIn && nOut == nIn && vOut == vIn);
    end
    if (opCode == 4'd6 || opCode == 4'd7 || opCode == 4'd10) begin
      assert_logic_flags_R5: assert (!vOut && (cOut == !zOut));
    end
    if (opCode == 4'd0) begin
      assert_move_pass_R1: assert (result == (byteMode ? {8'h00, srcOp[7:0]} : srcOp));
    end
  end

endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2ns clk = ~clk;

  logic [15:0] srcOp = '0, dstOp = '0;
  logic [3:0]  opCode = '0;
  logic        byteMode = 1'b0, cIn = 1'b0, zIn = 1'b0, nIn = 1'b0, vIn = 1'b0;
  logic [15:0] result;
  logic        writeEn, cOut, zOut, nOut, vOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu16_core dut_i (
    .srcOp(srcOp), .dstOp(dstOp), .opCode(opCode), .byteMode(byteMode),
    .cIn(cIn), .zIn(zIn), .nIn(nIn), .vIn(vIn),
    .result(result), .writeEn(writeEn),
    .cOut(cOut), .zOut(zOut), .nOut(nOut), .vOut(vOut)
  );

  function automatic string reqOf(int op, bit bm);
    if (bm && op != 14 && op != 15) return "R10";
    case (op)
      0: return "R1";   1, 2: return "R2";  3, 4: return "R3";
      5, 7: return "R4"; 6, 10: return "R5"; 8, 9: return "R6";
      11: return "R7";  12, 13: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: integers only.
  task automatic model(input int op, input bit bm, input int s, input int d,
                       input bit c, input bit z, input bit n, input bit v,
                       output int r, output bit we, output bit co, output bit zo,
                       output bit no, output bit vo);
    bit wordOp = (op == 14 || op == 15);
    int m   = (bm && !wordOp) ? 'hFF : 'hFFFF;
    int sb  = (bm && !wordOp) ? 'h80 : 'h8000;
    int a   = d & m;
    int b   = s & m;
    int sum;
    bit keep = 0, arith = 0;
    co = c; vo = 0;
    we = !(op == 5 || op == 7);
    case (op)
      0: begin r = b; keep = 1; end
      1, 2: begin sum = a + b + ((op == 2) ? int'(c) : 0); arith = 1; end
      3, 4, 5: begin b = (~s) & m; sum = a + b + ((op == 4) ? int'(c) : 1); arith = 1; end
      6, 7: r = a & b;
      8: begin r = (~b) & a; keep = 1; end
      9: begin r = a | b; keep = 1; end
      10: r = a ^ b;
      11: begin
        int cy = c;
        int nd = (m == 'hFF) ? 2 : 4;
        r = 0;
        for (int k = 0; k < nd; k++) begin
          int t = ((a >> (4*k)) & 15) + ((b >> (4*k)) & 15) + cy;
          if (t > 9) begin t = t + 6; cy = 1; end else cy = 0;
          r = r | ((t & 15) << (4*k));
        end
        co = cy;
      end
      12: begin r = (a >> 1) | (a & sb); co = a & 1; end
      13: begin r = (a >> 1) | (c ? sb : 0); co = a & 1; end
      14: begin r = ((d & 'hFF) << 8) | ((d >> 8) & 'hFF); keep = 1; end
      default: r = ((d & 'h80) != 0) ? ((d & 'hFF) | 'hFF00) : (d & 'hFF);
    endcase
    if (arith) begin
      r  = sum & m;
      co = (sum > m);
      vo = ((a & sb) == (b & sb)) && ((r & sb) != (a & sb));
    end
    if (op == 6 || op == 7 || op == 10 || op == 15) co = (r != 0);
    if (keep) begin co = c; zo = z; no = n; vo = v; end
    else begin zo = (r == 0); no = (r & sb) != 0; end
  endtask

  task automatic apply(int op, bit bm, int s, int d, bit c, bit z, bit n, bit v);
    int r; bit we, co, zo, no, vo;
    string q;
    @(posedge clk);
    opCode <= 4'(op); byteMode <= bm; srcOp <= 16'(s); dstOp <= 16'(d);
    cIn <= c; zIn <= z; nIn <= n; vIn <= v;
    @(negedge clk);
    model(op, bm, s, d, c, z, n, v, r, we, co, zo, no, vo);
    q = reqOf(op, bm);
    checkVal(q, "result", int'(result), r);
    checkVal((op == 5 || op == 7) ? "R4" : "R11", "writeEn", int'(writeEn), int'(we));
    checkVal(q, "C", int'(cOut), int'(co));
    checkVal(q, "Z", int'(zOut), int'(zo));
    checkVal(q, "N", int'(nOut), int'(no));
    checkVal(q, "V", int'(vOut), int'(vo));
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state after reset: MOV of zeros, R1
    checkVal("R1", "reset result", int'(result), 0);
    checkVal("R11", "reset writeEn", int'(writeEn), 1);
    checkVal("R1", "reset flags", int'({cOut, zOut, nOut, vOut}), 0);

    apply(0, 0, 'h1234, 'h5555, 1, 0, 1, 1);   // R1 MOV keeps flags
    apply(3, 0, 13, 12, 0, 0, 0, 0);           // R3 12-13 = FFFF, N, borrow
    apply(1, 0, 1, 'h7FFF, 0, 0, 0, 0);        // R2 overflow
    apply(1, 0, 'h000E, 'hFFFE, 0, 0, 0, 0);   // R2 carry out
    apply(2, 0, 0, 'hFFFF, 1, 0, 0, 0);        // R2 ADDC wraps to zero
    apply(4, 0, 5, 5, 0, 0, 0, 0);             // R3 SUBC with C=0
    apply(5, 0, 7, 7, 0, 0, 0, 0);             // R4 CMP equal
    apply(7, 0, 'hF0F0, 'h0F0F, 1, 0, 0, 1);   // R4 BIT zero
    apply(10, 0, 'h8000, 'h8001, 0, 0, 0, 1);  // R5 XOR
    apply(8, 0, 'h00FF, 'h1234, 1, 1, 0, 1);   // R6 BIC
    apply(9, 0, 'h00F0, 'h1200, 0, 1, 1, 0);   // R6 BIS
    apply(11, 0, 'h0001, 'h0999, 0, 0, 0, 0);  // R7 BCD ripple
    apply(11, 0, 'h0000, 'h9999, 1, 0, 0, 0);  // R7 decimal carry out
    apply(12, 0, 0, 'h8003, 0, 0, 0, 0);       // R8 RRA
    apply(13, 0, 0, 'h0002, 1, 0, 0, 0);       // R8 RRC
    apply(14, 1, 0, 'h12AB, 1, 0, 1, 0);       // R9 SWPB ignores byte mode
    apply(15, 1, 0, 'h0080, 0, 0, 0, 1);       // R9 SXT ignores byte mode
    apply(1, 1, 1, 'h7F, 0, 0, 0, 0);          // R10 byte overflow
    apply(1, 1, 1, 'h12FF, 0, 0, 0, 0);        // R10 byte carry
    apply(11, 1, 'h01, 'h0099, 0, 0, 0, 0);    // R10 byte BCD carry
    apply(13, 1, 0, 'hFF02, 1, 0, 0, 0);       // R10 byte RRC

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 15);
      int s = $urandom_range(0, 'hFFFF);
      int d = $urandom_range(0, 'hFFFF);
      apply(op, 1'($urandom_range(0, 1)), s, d, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule